// File: doc/BRIEF.md
# I2C Serial Memory Slave Command Engine

This block is the command front end of a 1K-by-8 serial memory that sits on a two-wire I2C bus as a slave. It runs entirely on the chip's system clock. It oversamples the already-filtered SCL and SDA lines and finds start and stop conditions. It shifts in the slave address, the word address and the write data. It answers on SDA through an open-drain pull-low output that is driven only while SCL is low.

Writes leave the engine one byte at a time through a single-cycle handoff to a page buffer. The engine raises a commit pulse when a stop closes a write that carried data. Reads fetch bytes through a byte-wide memory read port. The engine keeps the internal address register, which serves random, current and sequential reads. A busy input from the write-cycle controller makes the engine ignore new commands while an internal write runs. A strap input selects which of two device positions on the bus the engine answers to.

Top module: `i2cMemSlave`

## Requirements
- R1: A start (SDA falling while SCL is high) at any point restarts slave-address reception. A stop (SDA rising while SCL is high) returns the engine to idle with SDA released. A start followed at once by a stop during command input produces no write strobe and no commit.
- R2: The first byte after a start is accepted only when its bits 7..4 equal 1010 and its bit 3 equals `strapA2`. Bit 0 is the direction, with 1 meaning read. On a mismatch SDA stays released during the ninth clock and for every later byte until the next start.
- R3: The engine pulls SDA low for the whole ninth SCL clock after an accepted slave address and after every received word-address byte and write-data byte. `sdaPullLow` changes only while SCL is low.
- R4: For a write command, the memory address is {slave-address bits 2..1, word address}. Each received data byte is presented on `wrAddr`/`wrData` with `wrValid` high for exactly one clock.
- R5: Within one write command, consecutive data bytes advance only the low 4 address bits, so 10Eh is followed by 10Fh and then 100h.
- R6: A stop that ends a write command carrying at least one data byte gives a one-clock `wrCommit` pulse. A stop after a command with no data byte gives none.
- R7: A read sends 8 bits MSB first, taken from `memRdData` at `memRdAddr`, then releases SDA to sample the master. A low acknowledge sends the byte at the next address, wrapping 3FFh to 000h. A high acknowledge keeps SDA released until a stop or start.
- R8: A read command with no word-address phase returns the byte at the last accessed address plus one. The page bits of the read slave address are ignored.
- R9: While `busyIn` is high at the end of the slave-address byte, the command is ignored and not acknowledged.
- R10: A start or stop that arrives while read data is being sent, before the master's high acknowledge, marks the address undefined. A current read is then not acknowledged until a word address has been written.
- R11: Dummy SCL clocks with SDA released, followed by a start, bring the engine back to address reception. The next valid command is acknowledged and no write strobe results from the dummy clocks.
- R12: After reset SDA is released, `wrValid` and `wrCommit` are low, and the internal address is 000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Filtered serial clock line |
| sdaIn | input | 1 | Filtered serial data line (bus level) |
| strapA2 | input | 1 | Device-select strap compared with slave-address bit 3 |
| busyIn | input | 1 | High while the internal write cycle runs |
| sdaPullLow | output | 1 | Open-drain enable: 1 pulls SDA low |
| memRdAddr | output | ADDR_W | Address of the byte to be sent next |
| memRdData | input | 8 | Memory byte at memRdAddr |
| wrValid | output | 1 | One-clock strobe for a received write byte |
| wrAddr | output | ADDR_W | Memory address of the write byte |
| wrData | output | 8 | Write byte value |
| wrCommit | output | 1 | One-clock pulse when a stop closes a write with data |

## Verification
The bench builds the engine with its defaults: a 10-bit address, a 4-bit page roll and a two-stage synchronizer. With these values the 3FFh-to-000h wrap of a sequential read is reached in three bytes, and the 16-byte write roll is reached by a write that starts at word 0Eh. The bench runs the bus a quarter SCL period of ten system clocks. This leaves the synchronizer latency well inside the SCL low time, so the bench can sample acknowledge and read bits in the middle of SCL high.

// File: rtl/i2cMemSlavePkg.sv
package i2cMemSlavePkg;

  typedef enum logic [3:0] {
    ST_IDLE,   // waiting for a start
    ST_DEV,    // shifting the slave address
    ST_ACK,    // driving the ninth-clock acknowledge
    ST_WORD,   // shifting the word address
    ST_DATA,   // shifting write data
    ST_RDATA,  // sending read data
    ST_RACK,   // waiting for the master acknowledge bit
    ST_RNEXT,  // master acknowledged, next byte loads at SCL fall
    ST_WAIT    // read finished, waiting for stop or start
  } engState_e;

  typedef enum logic [1:0] {
    NX_WORD,
    NX_DATA,
    NX_READ
  } afterAck_e;

  // datapath -> control
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startEvt;
    logic stopEvt;
    logic sdaBit;
    logic devMatch;
    logic rwBit;
    logic addrValid;
    logic txMsb;
  } busEvt_t;

  // control -> datapath
  typedef struct packed {
    logic shiftRx;
    logic latchPage;
    logic setWord;
    logic loadTx;
    logic shiftTx;
    logic pushWr;
    logic invalidate;
  } ctlStrobe_t;

endpackage

// File: rtl/i2cMemSlaveDp.sv
module i2cMemSlaveDp
  import i2cMemSlavePkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_ROLL_W = 4,
  parameter int SYNC_LEN = 2,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapA2,
  input  logic [7:0]        memRdData,
  input  ctlStrobe_t        ctl,
  output busEvt_t           evt,
  output logic [ADDR_W-1:0] memRdAddr,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData
);

  localparam int PSEL_W = ADDR_W - 8;
  localparam logic [PAGE_ROLL_W-1:0] ROLL_ONE = 1;
  localparam logic [ADDR_W-1:0] ADDR_ONE = 1;

  logic [SYNC_LEN-1:0] sclSync, sdaSync;
  logic sclQ, sdaQ, sclD, sdaD;
  logic [7:0] rxReg, txReg;
  logic [ADDR_W-1:0] addrReg;
  logic addrValid;
  logic [PSEL_W-1:0] pageReg;
  logic [PAGE_ROLL_W-1:0] rollLow;
  logic [ADDR_W-1:0] rollAddr;

  assign sclQ = sclSync[SYNC_LEN-1];
  assign sdaQ = sdaSync[SYNC_LEN-1];

  // oversampling synchronizer; idle bus level is high
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclD <= 1'b1;
      sdaD <= 1'b1;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_LEN; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
      sclD <= sclQ;
      sdaD <= sdaQ;
    end
  end

  assign evt.sclRise   = sclQ & ~sclD;
  assign evt.sclFall   = ~sclQ & sclD;
  assign evt.startEvt  = sclQ & sclD & sdaD & ~sdaQ;
  assign evt.stopEvt   = sclQ & sclD & ~sdaD & sdaQ;
  assign evt.sdaBit    = sdaQ;
  assign evt.devMatch  = (rxReg[7:4] == DEV_CODE) && (rxReg[3] == strapA2);
  assign evt.rwBit     = rxReg[0];
  assign evt.addrValid = addrValid;
  assign evt.txMsb     = txReg[7];

  // page roll keeps the upper bits of the write address
  assign rollLow  = addrReg[PAGE_ROLL_W-1:0] + ROLL_ONE;
  assign rollAddr = {addrReg[ADDR_W-1:PAGE_ROLL_W], rollLow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxReg <= '0;
      txReg <= '0;
      addrReg <= '0;
      addrValid <= 1'b1;
      pageReg <= '0;
      wrValid <= 1'b0;
      wrAddr <= '0;
      wrData <= '0;
    end else begin
      wrValid <= 1'b0;
      if (ctl.shiftRx) rxReg <= {rxReg[6:0], sdaQ};
      if (ctl.latchPage) pageReg <= rxReg[PSEL_W:1];
      if (ctl.shiftTx) txReg <= {txReg[6:0], 1'b0};
      if (ctl.invalidate) addrValid <= 1'b0;
      if (ctl.setWord) begin
        addrReg <= {pageReg, rxReg};
        addrValid <= 1'b1;
      end else if (ctl.loadTx) begin
        txReg <= memRdData;
        addrReg <= addrReg + ADDR_ONE;
      end else if (ctl.pushWr) begin
        wrValid <= 1'b1;
        wrAddr <= addrReg;
        wrData <= rxReg;
        addrReg <= rollAddr;
      end
    end
  end

  assign memRdAddr = addrReg;

endmodule

// File: rtl/i2cMemSlaveCtl.sv
module i2cMemSlaveCtl
  import i2cMemSlavePkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  busEvt_t    evt,
  input  logic       busyIn,
  output ctlStrobe_t ctl,
  output logic       sdaPullLow,
  output logic       wrCommit
);

  engState_e state, stateN;
  afterAck_e afterAck, afterAckN;
  logic [3:0] bitCnt, bitCntN;
  logic gotData, gotDataN, commitN;
  logic inRead, byteDone;

  assign inRead   = (state == ST_RDATA) || (state == ST_RACK) || (state == ST_RNEXT);
  assign byteDone = evt.sclFall && (bitCnt == 4'd8);

  always_comb begin
    stateN = state;
    afterAckN = afterAck;
    bitCntN = bitCnt;
    gotDataN = gotData;
    commitN = 1'b0;
    ctl = '0;
    if (evt.startEvt) begin
      ctl.invalidate = inRead;
      stateN = ST_DEV;
      bitCntN = '0;
      gotDataN = 1'b0;
    end else if (evt.stopEvt) begin
      ctl.invalidate = inRead;
      commitN = gotData;
      gotDataN = 1'b0;
      stateN = ST_IDLE;
    end else begin
      case (state)
        ST_DEV, ST_WORD, ST_DATA: begin
          if (evt.sclRise && (bitCnt < 4'd8)) begin
            ctl.shiftRx = 1'b1;
            bitCntN = bitCnt + 4'd1;
          end else if (byteDone) begin
            bitCntN = '0;
            if (state == ST_DEV) begin
              if (evt.devMatch && !busyIn && (!evt.rwBit || evt.addrValid)) begin
                stateN = ST_ACK;
                afterAckN = evt.rwBit ? NX_READ : NX_WORD;
                ctl.latchPage = !evt.rwBit;
              end else begin
                stateN = ST_IDLE;
              end
            end else if (state == ST_WORD) begin
              ctl.setWord = 1'b1;
              stateN = ST_ACK;
              afterAckN = NX_DATA;
            end else begin
              ctl.pushWr = 1'b1;
              gotDataN = 1'b1;
              stateN = ST_ACK;
              afterAckN = NX_DATA;
            end
          end
        end
        ST_ACK: begin
          if (evt.sclFall) begin
            bitCntN = '0;
            case (afterAck)
              NX_READ: begin
                ctl.loadTx = 1'b1;
                stateN = ST_RDATA;
              end
              NX_WORD: stateN = ST_WORD;
              default: stateN = ST_DATA;
            endcase
          end
        end
        ST_RDATA: begin
          if (evt.sclFall) begin
            if (bitCnt == 4'd7) begin
              stateN = ST_RACK;
              bitCntN = '0;
            end else begin
              ctl.shiftTx = 1'b1;
              bitCntN = bitCnt + 4'd1;
            end
          end
        end
        ST_RACK: begin
          if (evt.sclRise) stateN = evt.sdaBit ? ST_WAIT : ST_RNEXT;
        end
        ST_RNEXT: begin
          if (evt.sclFall) begin
            ctl.loadTx = 1'b1;
            bitCntN = '0;
            stateN = ST_RDATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      afterAck <= NX_WORD;
      bitCnt <= '0;
      gotData <= 1'b0;
      wrCommit <= 1'b0;
    end else begin
      state <= stateN;
      afterAck <= afterAckN;
      bitCnt <= bitCntN;
      gotData <= gotDataN;
      wrCommit <= commitN;
    end
  end

  // both terms come from registers updated at the same edge
  assign sdaPullLow = (state == ST_ACK) || ((state == ST_RDATA) && !evt.txMsb);

endmodule

// File: rtl/i2cMemSlave.sv
module i2cMemSlave
  import i2cMemSlavePkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int PAGE_ROLL_W = 4,
  parameter int SYNC_LEN = 2,
  parameter logic [3:0] DEV_CODE = 4'b1010
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              strapA2,
  input  logic              busyIn,
  output logic              sdaPullLow,
  output logic [ADDR_W-1:0] memRdAddr,
  input  logic [7:0]        memRdData,
  output logic              wrValid,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [7:0]        wrData,
  output logic              wrCommit
);

  busEvt_t busEvt;
  ctlStrobe_t ctlStb;
  logic startEvt, stopEvt;

  assign startEvt = busEvt.startEvt;
  assign stopEvt  = busEvt.stopEvt;

  i2cMemSlaveDp #(
    .ADDR_W(ADDR_W),
    .PAGE_ROLL_W(PAGE_ROLL_W),
    .SYNC_LEN(SYNC_LEN),
    .DEV_CODE(DEV_CODE)
  ) u_dp (
    .clk(clk),
    .rstN(rstN),
    .sclIn(sclIn),
    .sdaIn(sdaIn),
    .strapA2(strapA2),
    .memRdData(memRdData),
    .ctl(ctlStb),
    .evt(busEvt),
    .memRdAddr(memRdAddr),
    .wrValid(wrValid),
    .wrAddr(wrAddr),
    .wrData(wrData)
  );

  i2cMemSlaveCtl u_ctl (
    .clk(clk),
    .rstN(rstN),
    .evt(busEvt),
    .busyIn(busyIn),
    .ctl(ctlStb),
    .sdaPullLow(sdaPullLow),
    .wrCommit(wrCommit)
  );

endmodule

// File: rtl/i2cMemSlaveChk.sv
module i2cMemSlaveChk #(
  parameter int ADDR_W = 10,
  parameter int PAGE_ROLL_W = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              sclIn,
  input logic              sdaPullLow,
  input logic              wrValid,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrCommit,
  input logic              startEvt,
  input logic              stopEvt
);

  localparam logic [PAGE_ROLL_W-1:0] STEP = 1;

  logic inBurst;
  logic [ADDR_W-1:0] lastAddr;
  logic [PAGE_ROLL_W-1:0] lowNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      inBurst <= 1'b0;
      lastAddr <= '0;
    end else if (startEvt || stopEvt) begin
      inBurst <= 1'b0;
    end else if (wrValid) begin
      inBurst <= 1'b1;
      lastAddr <= wrAddr;
    end
  end

  assign lowNext = lastAddr[PAGE_ROLL_W-1:0] + STEP;

  assert_sda_moves_scl_low_R3: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullLow != $past(sdaPullLow)) |-> !sclIn);

  assert_wr_single_pulse_R4: assert property (@(posedge clk) disable iff (!rstN)
    wrValid |=> !wrValid);

  assert_commit_single_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    wrCommit |=> !wrCommit);

  assert_page_roll_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && inBurst) |->
      (wrAddr == {lastAddr[ADDR_W-1:PAGE_ROLL_W], lowNext}));

  assert_stop_releases_R1: assert property (@(posedge clk) disable iff (!rstN)
    stopEvt |=> !sdaPullLow);

endmodule

bind i2cMemSlave i2cMemSlaveChk #(
  .ADDR_W(ADDR_W),
  .PAGE_ROLL_W(PAGE_ROLL_W)
) u_chk (
  .clk(clk),
  .rstN(rstN),
  .sclIn(sclIn),
  .sdaPullLow(sdaPullLow),
  .wrValid(wrValid),
  .wrAddr(wrAddr),
  .wrCommit(wrCommit),
  .startEvt(startEvt),
  .stopEvt(stopEvt)
);

// File: tb/i2cMemSlave_tb.sv
`timescale 1ns/1ps
module i2cMemSlave_tb;

  localparam int ADDR_W = 10;
  localparam int Q = 10;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0;
  logic mScl = 1'b1, mSda = 1'b1;
  logic busyIn = 1'b0;
  logic sdaBus, sdaPullLow, wrValid, wrCommit;
  logic [ADDR_W-1:0] memRdAddr, wrAddr;
  logic [7:0] memRdData, wrData;
  logic [7:0] mem [0:1023];
  logic [ADDR_W-1:0] wrLogAddr [0:15];
  logic [7:0] wrLogData [0:15];
  int wrCount = 0;
  int commitCount = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  assign sdaBus = mSda & ~sdaPullLow;
  assign memRdData = mem[memRdAddr];

  i2cMemSlave u_dut (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaBus), .strapA2(1'b1),
    .busyIn(busyIn), .sdaPullLow(sdaPullLow), .memRdAddr(memRdAddr),
    .memRdData(memRdData), .wrValid(wrValid), .wrAddr(wrAddr),
    .wrData(wrData), .wrCommit(wrCommit)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  // memory model and page-buffer log
  always @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < 1024; i++) mem[i] <= pat(i);
    end else if (wrValid) begin
      mem[wrAddr] <= wrData;
      wrLogAddr[wrCount[3:0]] <= wrAddr;
      wrLogData[wrCount[3:0]] <= wrData;
      wrCount <= wrCount + 1;
    end
  end

  always @(posedge clk) if (rstN && wrCommit) commitCount <= commitCount + 1;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busStart();
    mSda = 1'b1; idle(Q);
    mScl = 1'b1; idle(Q);
    mSda = 1'b0; idle(Q);
    mScl = 1'b0; idle(Q);
  endtask

  task automatic busStop();
    mSda = 1'b0; idle(Q);
    mScl = 1'b1; idle(Q);
    mSda = 1'b1; idle(2 * Q);
  endtask

  task automatic sendBit(input logic b);
    mSda = b; idle(Q);
    mScl = 1'b1; idle(2 * Q);
    mScl = 1'b0; idle(Q);
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    for (int i = 7; i >= 0; i--) sendBit(v[i]);
    mSda = 1'b1; idle(Q);
    mScl = 1'b1; idle(Q);
    ack = sdaBus; idle(Q);
    mScl = 1'b0; idle(Q);
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      mSda = 1'b1; idle(Q);
      mScl = 1'b1; idle(Q);
      v = {v[6:0], sdaBus}; idle(Q);
      mScl = 1'b0; idle(Q);
    end
    mSda = nack; idle(Q);
    mScl = 1'b1; idle(2 * Q);
    mScl = 1'b0; idle(Q);
  endtask

  task automatic randomRead(input logic [9:0] a, output logic allAck);
    logic k1, k2, k3;
    busStart();
    sendByte({4'b1010, 1'b1, a[9:8], 1'b0}, k1);
    sendByte(a[7:0], k2);
    busStart();
    sendByte(8'hA9, k3);
    allAck = !(k1 | k2 | k3);
  endtask

  task automatic tResetState();
    chk(sdaPullLow == 1'b0, "R12 sda released", int'(sdaPullLow), 0);
    chk(wrValid == 1'b0 && wrCommit == 1'b0, "R12 strobes low", int'(wrValid), 0);
    chk(memRdAddr == 10'h000, "R12 address 000", int'(memRdAddr), 0);
  endtask

  task automatic tByteWrite();
    logic a1, a2, a3;
    int wc0 = wrCount, cc0 = commitCount;
    busStart();
    sendByte(8'hAC, a1);
    sendByte(8'h34, a2);
    sendByte(8'h5A, a3);
    busStop();
    idle(4);
    chk(!(a1 | a2 | a3), "R3 write acks low", int'({a1, a2, a3}), 0);
    chk(wrCount == wc0 + 1, "R4 one write strobe", wrCount - wc0, 1);
    chk(wrLogAddr[wc0[3:0]] == 10'h234, "R4 page+word address", int'(wrLogAddr[wc0[3:0]]), 'h234);
    chk(wrLogData[wc0[3:0]] == 8'h5A, "R4 write data", int'(wrLogData[wc0[3:0]]), 'h5A);
    chk(commitCount == cc0 + 1, "R6 commit on stop", commitCount - cc0, 1);
  endtask

  task automatic tCurrentAfterWrite();
    logic a;
    logic [7:0] v;
    busStart();
    sendByte(8'hA9, a);
    recvByte(1'b1, v);
    busStop();
    chk(a == 1'b0, "R8 current read ack", int'(a), 0);
    chk(v == pat('h235), "R8 current read last+1, page bits ignored", int'(v), int'(pat('h235)));
  endtask

  task automatic tRandomRead();
    logic ok;
    logic [7:0] v;
    randomRead(10'h234, ok);
    recvByte(1'b1, v);
    busStop();
    chk(ok, "R7 random read acks", int'(ok), 1);
    chk(v == 8'h5A, "R7 random read data", int'(v), 'h5A);
  endtask

  task automatic tSeqWrap();
    logic ok, a;
    logic [7:0] v0, v1, v2, v3;
    randomRead(10'h3FE, ok);
    recvByte(1'b0, v0);
    recvByte(1'b0, v1);
    recvByte(1'b1, v2);
    busStop();
    chk(v0 == pat('h3FE) && v1 == pat('h3FF), "R7 sequential bytes", int'({v0, v1}),
        int'({pat('h3FE), pat('h3FF)}));
    chk(v2 == pat(0), "R7 wrap 3FF to 000", int'(v2), int'(pat(0)));
    busStart();
    sendByte(8'hA9, a);
    recvByte(1'b1, v3);
    busStop();
    chk(a == 1'b0 && v3 == pat(1), "R8 current read after nack+stop", int'(v3), int'(pat(1)));
  endtask

  task automatic tPageRoll();
    logic a0, a1, a2, a3, a4;
    int wc0 = wrCount, cc0 = commitCount;
    busStart();
    sendByte(8'hAA, a0);
    sendByte(8'h0E, a1);
    sendByte(8'h11, a2);
    sendByte(8'h22, a3);
    sendByte(8'h33, a4);
    busStop();
    idle(4);
    chk(!(a0 | a1 | a2 | a3 | a4), "R3 page write acks", int'({a0, a1, a2, a3, a4}), 0);
    chk(wrCount == wc0 + 3, "R5 three strobes", wrCount - wc0, 3);
    chk(wrLogAddr[wc0[3:0]] == 10'h10E && wrLogAddr[4'(wc0 + 1)] == 10'h10F,
        "R5 first two addresses", int'(wrLogAddr[4'(wc0 + 1)]), 'h10F);
    chk(wrLogAddr[4'(wc0 + 2)] == 10'h100, "R5 roll to page start", int'(wrLogAddr[4'(wc0 + 2)]), 'h100);
    chk(commitCount == cc0 + 1, "R6 page commit", commitCount - cc0, 1);
  endtask

  task automatic tWrongAddr();
    logic a1, a2, a3;
    busStart();
    sendByte(8'hA0, a1);
    sendByte(8'h00, a2);
    busStop();
    busStart();
    sendByte(8'hB8, a3);
    busStop();
    chk(a1 == 1'b1, "R2 strap mismatch nack", int'(a1), 1);
    chk(a2 == 1'b1, "R2 silent after mismatch", int'(a2), 1);
    chk(a3 == 1'b1, "R2 device code mismatch nack", int'(a3), 1);
  endtask

  task automatic tBusy();
    logic a1, a2;
    int cc0 = commitCount;
    busyIn = 1'b1;
    busStart();
    sendByte(8'hA8, a1);
    busStop();
    busyIn = 1'b0;
    busStart();
    sendByte(8'hA8, a2);
    busStop();
    idle(4);
    chk(a1 == 1'b1, "R9 busy nack", int'(a1), 1);
    chk(a2 == 1'b0, "R9 ack after busy clears", int'(a2), 0);
    chk(commitCount == cc0, "R6 no commit without data", commitCount - cc0, 0);
  endtask

  task automatic tReadAbort();
    logic ok, a, ok2;
    logic [7:0] v, v2;
    randomRead(10'h050, ok);
    recvByte(1'b0, v);
    busStart();
    busStop();
    chk(ok && v == pat('h050), "R7 read before abort", int'(v), int'(pat('h050)));
    busStart();
    sendByte(8'hA9, a);
    busStop();
    chk(a == 1'b1, "R10 current read nack when undefined", int'(a), 1);
    randomRead(10'h050, ok2);
    recvByte(1'b1, v2);
    busStop();
    chk(ok2 && v2 == pat('h050), "R10 random read restores", int'(v2), int'(pat('h050)));
  endtask

  task automatic tSoftReset();
    logic a;
    int wc0 = wrCount;
    busStart();
    sendBit(1'b0); sendBit(1'b1); sendBit(1'b1); sendBit(1'b0);
    for (int i = 0; i < 9; i++) sendBit(1'b1);
    busStart();
    sendByte(8'hA8, a);
    busStop();
    chk(a == 1'b0, "R11 command after dummy clocks acked", int'(a), 0);
    chk(wrCount == wc0, "R11 no strobe from dummy clocks", wrCount - wc0, 0);
  endtask

  task automatic tWriteAbort();
    logic a1, a2;
    int wc0 = wrCount, cc0 = commitCount;
    busStart();
    sendByte(8'hA8, a1);
    sendByte(8'h10, a2);
    busStart();
    busStop();
    idle(4);
    chk(!(a1 | a2), "R3 acks before abort", int'({a1, a2}), 0);
    chk(wrCount == wc0 && commitCount == cc0, "R1 start+stop abort, no write",
        wrCount - wc0 + commitCount - cc0, 0);
    chk(sdaPullLow == 1'b0, "R1 idle releases sda", int'(sdaPullLow), 0);
  endtask

  initial begin
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", LIMIT, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(6);
    rstN = 1'b1;
    idle(6);
    tResetState();
    tByteWrite();
    tCurrentAfterWrite();
    tRandomRead();
    tSeqWrap();
    tPageRoll();
    tWrongAddr();
    tBusy();
    tReadAbort();
    tSoftReset();
    tWriteAbort();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule